// File: doc/BRIEF.md
# Raster Timing and Vertical-Blank Interrupt Unit

This block keeps the beam position for a retro game console's picture processor. Two cascaded counters track the dot within a scanline and the scanline within a frame. Both advance only on clock edges where the shared dot-clock enable is high. From those counts the block derives an active-video strobe for the visible 256 by 240 window. It also keeps a vertical-blank flag, which is raised when scanline 241 begins and dropped when the frame wraps back to line 0.

The CPU reaches the block through a small register port with two registers. The first is a control register. Its top bit gates the interrupt request. The second is a status register. It shows the blank flag in its top bit, and reading it clears the flag. Software can poll the status register, take the level-active interrupt request, or use both. Enabling the interrupt while the flag is already up raises the request at once.

Top module: `vtiming_unit`

## Requirements
- R1: A synchronous active-high reset clears the dot counter, the line counter, the control register and the blank flag. While reset is high the interrupt request is low.
- R2: The dot counter advances by one only on clock edges with `dot_en` high. It counts 0 to 282 and then returns to 0.
- R3: The line counter advances by one on each edge where the dot counter wraps. It counts 0 to 261 and then returns to 0.
- R4: `active_video` is high exactly when the dot count is below 256 and the line count is below 240.
- R5: The blank flag becomes 1 on the edge that moves the line counter from 240 to 241. It becomes 0 on the edge that moves the line counter from 261 to 0. Both of these events take priority over a status read on the same edge.
- R6: A status read is `cpu_sel`=1, `cpu_we`=0 and `cpu_addr`=2. During the read, `cpu_rdata` shows the blank flag in bit 7 and 0 in bits 6..0. The flag is cleared on that edge.
- R7: A control write is `cpu_sel`=1, `cpu_we`=1 and `cpu_addr`=0. It stores all 8 bits of `cpu_wdata`, and bit 7 is the interrupt enable. A control read at address 0 returns the stored byte.
- R8: `nmi_req` is a level that is high while both the blank flag and the enable bit are set. It goes high on the clock after the enable is written while the flag is up. It goes low on the clock after a status read clears the flag.
- R9: The following accesses leave the control register and the blank flag unchanged: a write to address 2, a read of address 0, and any cycle with `cpu_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable, one raster step per high cycle |
| cpu_sel | input | 1 | CPU access strobe for this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register index: 0 control, 2 status |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current access (combinational) |
| dot_x | output | 9 | Dot position within the scanline |
| line_y | output | 9 | Scanline within the frame |
| active_video | output | 1 | High inside the visible window |
| vblank | output | 1 | Vertical-blank flag |
| nmi_req | output | 1 | Level-active interrupt request toward the CPU |

## Verification
The first pattern pulses `dot_en` in an irregular rhythm. This separates counters that respect the enable from counters that free-run. The next patterns hold `dot_en` high across two full frames. That run passes through both counter wraps, the active-window edges and the entry to line 241. During it, status reads and control writes are placed at chosen moments. These placements separate four behaviours: polling with the interrupt off, the interrupt on entry to blanking, the immediate interrupt when enabling inside blanking, and clearing of the flag by read versus by frame wrap. Accesses with a deselected strobe, or to the wrong address or direction, show whether register decode leaks into state.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL_WR,
        ACC_CTRL_RD,
        ACC_STAT_WR,
        ACC_STAT_RD
    } vt_access_e;

    typedef struct packed {
        logic       blank;
        logic [7:0] ctrl;
    } vt_regs_t;

    localparam int IRQ_EN_BIT = 7;
    localparam int FLAG_BIT   = 7;

endpackage

// File: rtl/vt_wrap_counter.sv
module vt_wrap_counter #(
    parameter int LIMIT = 283,
    parameter int W     = $clog2(LIMIT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc) begin
            if (count_q == LAST) count_d = '0;
            else                 count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
    assign wrap  = inc && (count_q == LAST);

    a_r2_hold_without_inc: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count_q));
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        count_q <= LAST);
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count_q == '0));
endmodule

// File: rtl/vt_regport_decode.sv
module vt_regport_decode
    import vt_pkg::*;
#(
    parameter int AW        = 3,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 2
) (
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output vt_access_e    acc
);
    always_comb begin
        acc = ACC_NONE;
        if (sel) begin
            if (addr == AW'(CTRL_ADDR))      acc = we ? ACC_CTRL_WR : ACC_CTRL_RD;
            else if (addr == AW'(STAT_ADDR)) acc = we ? ACC_STAT_WR : ACC_STAT_RD;
        end
    end
endmodule

// File: rtl/vt_blank_ctrl.sv
module vt_blank_ctrl
    import vt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_evt,
    input  logic       clr_evt,
    input  vt_access_e acc,
    input  logic [7:0] wdata,
    output logic       blank,
    output logic [7:0] ctrl,
    output logic       nmi
);
    vt_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (acc == ACC_CTRL_WR) regs_d.ctrl  = wdata;
        if (acc == ACC_STAT_RD) regs_d.blank = 1'b0;
        if (set_evt)            regs_d.blank = 1'b1;
        if (clr_evt)            regs_d.blank = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign blank = regs_q.blank;
    assign ctrl  = regs_q.ctrl;
    assign nmi   = regs_q.blank & regs_q.ctrl[IRQ_EN_BIT];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!regs_q.blank && regs_q.ctrl == 8'h00));
    a_r5_set_on_entry: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> regs_q.blank);
    a_r5_clear_on_wrap: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> !regs_q.blank);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_STAT_RD && !set_evt) |=> !regs_q.blank);
    a_r9_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
        (acc != ACC_CTRL_WR) |=> $stable(regs_q.ctrl));
endmodule

// File: rtl/vtiming_unit.sv
module vtiming_unit
    import vt_pkg::*;
#(
    parameter int DOTS_PER_LINE   = 283,
    parameter int LINES_PER_FRAME = 262,
    parameter int ACTIVE_DOTS     = 256,
    parameter int ACTIVE_LINES    = 240,
    parameter int BLANK_LINE      = 241,
    parameter int AW              = 3,
    parameter int CTRL_ADDR       = 0,
    parameter int STAT_ADDR       = 2,
    localparam int DW             = $clog2(DOTS_PER_LINE),
    localparam int LW             = $clog2(LINES_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dot_en,
    input  logic          cpu_sel,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    output logic [DW-1:0] dot_x,
    output logic [LW-1:0] line_y,
    output logic          active_video,
    output logic          vblank,
    output logic          nmi_req
);
    localparam logic [LW-1:0] PRE_BLANK = LW'(BLANK_LINE - 1);
    localparam logic [DW-1:0] ACT_DOTS  = DW'(ACTIVE_DOTS);
    localparam logic [LW-1:0] ACT_LINES = LW'(ACTIVE_LINES);

    logic       dot_wrap, line_wrap;
    logic       set_evt;
    logic [7:0] ctrl;
    vt_access_e acc;

    vt_wrap_counter #(.LIMIT(DOTS_PER_LINE), .W(DW)) u_dot_cnt (
        .clk(clk), .rst(rst), .inc(dot_en), .count(dot_x), .wrap(dot_wrap)
    );

    vt_wrap_counter #(.LIMIT(LINES_PER_FRAME), .W(LW)) u_line_cnt (
        .clk(clk), .rst(rst), .inc(dot_wrap), .count(line_y), .wrap(line_wrap)
    );

    vt_regport_decode #(.AW(AW), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_decode (
        .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr), .acc(acc)
    );

    assign set_evt = dot_wrap && (line_y == PRE_BLANK);

    vt_blank_ctrl u_blank (
        .clk(clk), .rst(rst), .set_evt(set_evt), .clr_evt(line_wrap),
        .acc(acc), .wdata(cpu_wdata), .blank(vblank), .ctrl(ctrl), .nmi(nmi_req)
    );

    assign active_video = (dot_x < ACT_DOTS) && (line_y < ACT_LINES);

    always_comb begin
        cpu_rdata = 8'h00;
        case (acc)
            ACC_CTRL_RD: cpu_rdata = ctrl;
            ACC_STAT_RD: cpu_rdata[FLAG_BIT] = vblank;
            default:     cpu_rdata = 8'h00;
        endcase
    end

    a_r8_nmi_rise_needs_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> vblank);
    a_r8_nmi_falls_after_read: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_STAT_RD && !set_evt) |=> !nmi_req);
    a_r3_line_moves_on_dot_wrap: assert property (@(posedge clk) disable iff (rst)
        !dot_wrap |=> $stable(line_y));
    a_r4_blank_outside_window: assert property (@(posedge clk) disable iff (rst)
        vblank |-> !active_video);
endmodule

// File: tb/vtiming_unit_tb.sv
module vtiming_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dot_en = 1'b0;
    logic       cpu_sel = 1'b0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [8:0] dot_x;
    logic [8:0] line_y;
    logic       active_video, vblank, nmi_req;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int m_dot = 0, m_line = 0, m_blank = 0, m_ctrl = 0;

    always #5 clk = ~clk;

    vtiming_unit u_dut (
        .clk(clk), .rst(rst), .dot_en(dot_en), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dot_x(dot_x), .line_y(line_y), .active_video(active_video),
        .vblank(vblank), .nmi_req(nmi_req)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_dot = 0; m_line = 0; m_blank = 0; m_ctrl = 0;
        end else begin
            if (cpu_sel && cpu_we && cpu_addr == 3'd0) m_ctrl = int'(cpu_wdata);
            if (cpu_sel && !cpu_we && cpu_addr == 3'd2) m_blank = 0;
            if (dot_en) begin
                if (m_dot == 282) begin
                    m_dot = 0;
                    if (m_line == 261) begin
                        m_line = 0; m_blank = 0;
                    end else begin
                        m_line++;
                        if (m_line == 241) m_blank = 1;
                    end
                end else m_dot++;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 dot", int'(dot_x), m_dot);
            chk("R3 line", int'(line_y), m_line);
            chk("R4 active", int'(active_video), int'(m_dot < 256 && m_line < 240));
            chk("R5 vblank", int'(vblank), m_blank);
            chk("R8 nmi", int'(nmi_req), int'(m_blank == 1 && m_ctrl >= 128));
        end
    end

    task automatic access(bit we, int addr, int wdata, bit sel, int exp_rd, string req);
        @(negedge clk);
        cpu_sel = sel; cpu_we = we; cpu_addr = 3'(addr); cpu_wdata = 8'(wdata);
        #1;
        if (sel && !we) chk(req, int'(cpu_rdata), exp_rd);
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_pos(int line, int dot);
        while (!(m_line == line && m_dot == dot)) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        dot_en = 1'b1;
        repeat (4) @(negedge clk);
        // R1: counters held at zero under reset, flag and request low
        chk("R1 dot", int'(dot_x), 0);
        chk("R1 line", int'(line_y), 0);
        chk("R1 vblank", int'(vblank), 0);
        chk("R1 nmi", int'(nmi_req), 0);
        rst = 1'b0;
        access(0, 0, 0, 1, 0, "R1 ctrl after reset");

        // R2: irregular enable rhythm
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            dot_en = ((i % 3) != 0) && ((i % 7) != 5);
        end
        dot_en = 1'b1;

        // R5: entry to blanking with interrupt disabled (poll mode)
        wait_pos(241, 0);
        chk("R5 flag up at 241", int'(vblank), 1);
        chk("R8 no nmi when disabled", int'(nmi_req), 0);
        // R9: status write and control read have no effect
        access(1, 2, 8'hFF, 1, 0, "R9");
        access(0, 0, 0, 1, 0, "R9 ctrl read");
        chk("R9 flag kept", int'(vblank), 1);
        // R6: read returns flag in bit 7 and clears it
        access(0, 2, 0, 1, 8'h80, "R6 status read");
        chk("R6 flag cleared", int'(vblank), 0);
        access(0, 2, 0, 1, 8'h00, "R6 second read");

        // R7: control write and readback; deselected write ignored (R9)
        access(1, 0, 8'hA5, 1, 0, "R7");
        access(0, 0, 0, 1, 8'hA5, "R7 ctrl readback");
        access(1, 0, 8'h00, 0, 0, "R9");
        access(0, 0, 0, 1, 8'hA5, "R9 deselected write");
        chk("R8 no nmi outside blank", int'(nmi_req), 0);

        // R8: interrupt on next entry to blanking
        wait_pos(241, 0);
        chk("R8 nmi at 241", int'(nmi_req), 1);
        access(1, 0, 8'h00, 1, 0, "R8 disable");
        chk("R8 nmi off after disable", int'(nmi_req), 0);
        access(1, 0, 8'h80, 1, 0, "R8 enable in blank");
        chk("R8 nmi immediate", int'(nmi_req), 1);
        chk("R8 flag kept", int'(vblank), 1);

        // R5: frame wrap clears flag and request
        wait_pos(0, 0);
        chk("R5 flag cleared at wrap", int'(vblank), 0);
        chk("R8 nmi cleared at wrap", int'(nmi_req), 0);
        chk("R3 line wrapped", int'(line_y), 0);
        @(negedge clk);
        finish_run();
    end
endmodule